// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block raises a message to a power modulo an odd modulus, `result = M^e mod n`, for a parameterised operand width `K`. It works only in the Montgomery domain with radix `r = 2^K`. The caller supplies two precomputed values along with the modulus and the exponent. The first is the message in Montgomery form, `M·r mod n`. The second is `r mod n`, which is the Montgomery form of one. Deriving these constants is the caller's job.

Internally, a bit-serial Montgomery multiplier computes `a·b·r^-1 mod n`. A sequencer drives that multiplier, using a left-to-right square-and-multiply walk over the exponent. Every exponent bit costs one squaring. A set bit adds a second product with the Montgomery-form message. At the end, one more product by plain one removes the `r` factor. A start pulse begins a run. `busy` stays high for the whole run. A one-cycle `done` pulse marks the cycle in which `result` becomes valid.

Top module: `mont_exp`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: For an odd modulus `n` and inputs `M < n`, `one_mont = 2^K mod n` and `msg_mont = M·2^K mod n`, the value on `result` at `done` equals `M^e mod n`.
- R3: An exponent of zero yields `1 mod n` for any message, including a message of zero.
- R4: `done` is high for exactly one clock cycle, and `busy` is already low in that cycle.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with the operands captured at its own start.
- R6: `result` changes only in the cycle in which `done` is high, and otherwise holds its value.
- R7: A `start` pulse accepted while idle makes `busy` high from the next cycle until `done`.
- R8: The value delivered on `result` is always strictly less than the modulus captured at start.
- R9: The boundary operands are handled correctly: an all-ones exponent (every bit both squares and multiplies), the message `n-1`, and the smallest modulus 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an exponentiation; ignored while busy |
| msg_mont | input | K | Message in Montgomery form, M·2^K mod n |
| one_mont | input | K | Montgomery form of one, 2^K mod n |
| modulus | input | K | Odd modulus n |
| exponent | input | K | Exponent e, scanned from bit K-1 down to bit 0 |
| busy | output | 1 | High while an exponentiation is in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | K | M^e mod n, held until the next completion |

## Verification
The accumulator is written back after every product. A wrong multiplier reduction or a misrouted operand therefore corrupts every later squaring. A single bad step reaches `result` at the next `done`, as a value that disagrees with `M^e mod n` and often lies at or above `n`. A wrong exponent-bit pointer, or a wrong sequencer transition, changes the number of products. That shows up either as a wrong power or as `done` arriving late or never. Sweeping many moduli, messages and exponent patterns at a small width exposes each of these faults within one operation.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SQR,
        SEQ_MUL,
        SEQ_CONV
    } seq_state_e;

    typedef enum logic [1:0] {
        MM_IDLE,
        MM_RUN,
        MM_FIX
    } mm_state_e;

    // Width of a counter able to hold values 0 .. n-1 (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mont_mul.sv
module mont_mul
    import mexp_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         kick,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modn,
    output logic         fin,
    output logic [W-1:0] prod
);
    localparam int unsigned AW = W + 2;
    localparam int unsigned CW = idx_width(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    mm_state_e      st;
    logic [W-1:0]   a_sh;
    logic [W-1:0]   b_q;
    logic [W-1:0]   n_q;
    logic [AW-1:0]  acc;
    logic [CW-1:0]  step;

    logic [AW-1:0]  add_b;
    logic [AW-1:0]  add_n;
    logic [AW-1:0]  acc_nxt;
    logic [AW-1:0]  n_ext;
    logic [AW-1:0]  acc_red;
    logic           acc_ge;

    always_comb begin
        n_ext   = {2'b00, n_q};
        add_b   = acc + (a_sh[0] ? {2'b00, b_q} : '0);
        add_n   = add_b[0] ? (add_b + n_ext) : add_b;
        acc_nxt = add_n >> 1;
        acc_ge  = (acc >= n_ext);
        acc_red = acc - n_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MM_IDLE;
            fin  <= 1'b0;
            prod <= '0;
            a_sh <= '0;
            b_q  <= '0;
            n_q  <= '0;
            acc  <= '0;
            step <= '0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                MM_IDLE: begin
                    if (kick) begin
                        a_sh <= op_a;
                        b_q  <= op_b;
                        n_q  <= modn;
                        acc  <= '0;
                        step <= '0;
                        st   <= MM_RUN;
                    end
                end
                MM_RUN: begin
                    acc  <= acc_nxt;
                    a_sh <= a_sh >> 1;
                    step <= step + 1'b1;
                    if (step == LAST_STEP) begin
                        st <= MM_FIX;
                    end
                end
                MM_FIX: begin
                    prod <= acc_ge ? acc_red[W-1:0] : acc[W-1:0];
                    fin  <= 1'b1;
                    st   <= MM_IDLE;
                end
                default: st <= MM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/exp_scan.sv
module exp_scan
    import mexp_pkg::*;
#(
    parameter int unsigned K = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [K-1:0] ex_in,
    output logic         cur_bit,
    output logic         last
);
    localparam int unsigned IW = idx_width(K);

    logic [K-1:0]  sh;
    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= ex_in;
            idx <= IW'(K - 1);
        end else if (adv) begin
            sh  <= sh << 1;
            idx <= idx - 1'b1;
        end
    end

    assign cur_bit = sh[K-1];
    assign last    = (idx == '0);

endmodule

// File: rtl/mont_exp.sv
module mont_exp
    import mexp_pkg::*;
#(
    parameter int unsigned K = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [K-1:0] msg_mont,
    input  logic [K-1:0] one_mont,
    input  logic [K-1:0] modulus,
    input  logic [K-1:0] exponent,
    output logic         busy,
    output logic         done,
    output logic [K-1:0] result
);
    localparam logic [K-1:0] PLAIN_ONE = K'(1);

    seq_state_e   st;
    logic [K-1:0] x_q;
    logic [K-1:0] m_q;
    logic [K-1:0] mod_q;
    logic         kick;

    logic [K-1:0] mm_a;
    logic [K-1:0] mm_b;
    logic         mm_fin;
    logic [K-1:0] mm_prod;

    logic         accept;
    logic         scan_adv;
    logic         bit_set;
    logic         bit_last;

    assign accept = start && (st == SEQ_IDLE);
    assign busy   = (st != SEQ_IDLE);

    always_comb begin
        unique case (st)
            SEQ_MUL: begin
                mm_a = m_q;
                mm_b = x_q;
            end
            SEQ_CONV: begin
                mm_a = x_q;
                mm_b = PLAIN_ONE;
            end
            default: begin
                mm_a = x_q;
                mm_b = x_q;
            end
        endcase
    end

    always_comb begin
        scan_adv = 1'b0;
        if (mm_fin && !bit_last) begin
            if (st == SEQ_SQR && !bit_set) scan_adv = 1'b1;
            if (st == SEQ_MUL)             scan_adv = 1'b1;
        end
    end

    exp_scan #(.K(K)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .adv     (scan_adv),
        .ex_in   (exponent),
        .cur_bit (bit_set),
        .last    (bit_last)
    );

    mont_mul #(.W(K)) u_mm (
        .clk  (clk),
        .rst  (rst),
        .kick (kick),
        .op_a (mm_a),
        .op_b (mm_b),
        .modn (mod_q),
        .fin  (mm_fin),
        .prod (mm_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            x_q    <= '0;
            m_q    <= '0;
            mod_q  <= '0;
            kick   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            kick <= 1'b0;
            done <= 1'b0;
            unique case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        x_q   <= one_mont;
                        m_q   <= msg_mont;
                        mod_q <= modulus;
                        kick  <= 1'b1;
                        st    <= SEQ_SQR;
                    end
                end
                SEQ_SQR: begin
                    if (mm_fin) begin
                        x_q  <= mm_prod;
                        kick <= 1'b1;
                        if (bit_set)       st <= SEQ_MUL;
                        else if (bit_last) st <= SEQ_CONV;
                    end
                end
                SEQ_MUL: begin
                    if (mm_fin) begin
                        x_q  <= mm_prod;
                        kick <= 1'b1;
                        st   <= bit_last ? SEQ_CONV : SEQ_SQR;
                    end
                end
                SEQ_CONV: begin
                    if (mm_fin) begin
                        result <= mm_prod;
                        done   <= 1'b1;
                        st     <= SEQ_IDLE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mont_exp_chk.sv
module mont_exp_chk #(
    parameter int unsigned K = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [K-1:0] result,
    input logic [K-1:0] mod_q
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !done) |=> busy); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R6

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R7

    AST_RESULT_BELOW_N: assert property (@(posedge clk) disable iff (rst)
        done |-> (result < mod_q)); // R8

endmodule

bind mont_exp mont_exp_chk #(.K(K)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .mod_q  (mod_q)
);

// File: tb/mont_exp_tb.sv
module mont_exp_tb;
    localparam int unsigned K      = 8;
    localparam time         CLK_T  = 10ns;
    localparam int          OP_MAX = 3000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [K-1:0] msg_mont = '0;
    logic [K-1:0] one_mont = '0;
    logic [K-1:0] modulus  = '0;
    logic [K-1:0] exponent = '0;
    logic         busy;
    logic         done;
    logic [K-1:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    mont_exp #(.K(K)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .msg_mont (msg_mont),
        .one_mont (one_mont),
        .modulus  (modulus),
        .exponent (exponent),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    function automatic longint ref_pow(longint m, longint e, longint n);
        longint acc = 1 % n;
        for (int i = K - 1; i >= 0; i--) begin
            acc = (acc * acc) % n;
            if (e[i]) acc = (acc * m) % n;
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic drive_start(input longint m, input longint e, input longint n);
        @(negedge clk);
        modulus  = K'(n);
        exponent = K'(e);
        one_mont = K'((longint'(1) << K) % n);
        msg_mont = K'(((m % n) << K) % n);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int cnt = 0;
        while (!done && cnt < OP_MAX) begin
            @(negedge clk);
            cnt++;
        end
        seen = done;
    endtask

    task automatic run_op(input longint m, input longint e, input longint n, input string tag);
        bit seen;
        longint exp_v = ref_pow(m, e, n);
        logic [K-1:0] held;
        drive_start(m, e, n);
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        wait_done(seen);
        chk(seen, {tag, " done arrives"}, seen, 1);
        if (seen) begin
            chk(result == K'(exp_v), tag, result, exp_v);
            chk(result < K'(n), "R8 result below modulus", result, n);
            chk(busy == 1'b0, "R4 busy low with done", busy, 0);
            held = result;
            @(negedge clk);
            chk(done == 1'b0, "R4 done single cycle", done, 0);
            repeat (2) @(negedge clk);
            chk(result == held, "R6 result held", result, held);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        longint mlist [4];
        longint elist [6];
        bit seen;
        elist = '{0, 1, 2, 255, 128, 165};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(result == '0, "R1 result after reset", result, 0);

        // R3: zero exponent, zero message
        run_op(0, 0, 97, "R3 zero exponent zero message");
        run_op(42, 0, 251, "R3 zero exponent");

        // R9: boundary operands
        run_op(2, 255, 3, "R9 modulus 3 all-ones exponent");
        run_op(250, 255, 251, "R9 message n-1 all-ones exponent");
        run_op(254, 3, 255, "R9 message n-1 odd exponent");

        // R2: sweep of moduli, messages and exponents
        for (int ni = 0; ni < 10; ni++) begin
            longint n = 3 + 28 * ni;
            mlist = '{0, 1, n - 1, n / 2};
            for (int mi = 0; mi < 4; mi++) begin
                for (int ei = 0; ei < 6; ei++) begin
                    run_op(mlist[mi], elist[ei], n, "R2 sweep");
                end
            end
        end

        // R5: start while busy is ignored
        drive_start(5, 200, 251);
        repeat (30) @(negedge clk);
        modulus  = K'(97);
        exponent = K'(3);
        msg_mont = K'(7);
        one_mont = K'(62);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        chk(busy == 1'b1, "R5 still busy after ignored start", busy, 1);
        wait_done(seen);
        chk(seen && result == K'(ref_pow(5, 200, 251)), "R5 ignored start result",
            result, ref_pow(5, 200, 251));
        @(negedge clk);
        chk(busy == 1'b0, "R5 no second run", busy, 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule